// File: doc/BRIEF.md
# Sector Transfer Sequencer for an ATA Disk Front End

The block carries one read, write or verify command through its life as a run of sector chunks. When a command is accepted it works out the real sector count and checks the requested range against the drive capacity. If the range is valid it keeps a running sector address and a count of remaining sectors. For each chunk it either issues a media request or opens a data-buffer window sized in 512-byte sectors. The order depends on direction. A read or verify fetches from media first and then hands the data to the host. A write collects the data from the host first and then commits it to media.

Interrupt requests follow the transfer mode. Programmed I/O raises one interrupt per chunk. DMA raises a single interrupt once both the command and its last buffer are finished. A set-multiple command programs the block size that programmed I/O uses outside single-sector mode. Register decoding, the sector store and the DMA engine sit outside the block. They reach it through simple pulse handshakes.

Top module: `sector_xfer_seq`

## Requirements
- R1: The effective count of a 28-bit command uses only `cmd_count[7:0]`, and 0 there means 256 sectors. A 48-bit command (`cmd_ext`=1) uses all 16 bits, and 0 there means 65536 sectors.
- R2: A command with `cmd_lba` > `cmd_cap`, or with `cmd_cap` − `cmd_lba` below the effective count, issues no media request and opens no buffer. It sets `err_pending`, sets `err_code` to 2'b01 and pulses `irq_set` once. A command that ends exactly at the capacity is accepted.
- R3: The chunk length is chosen as follows. With DMA it is min(remaining, MAX_MULT). In single-sector mode (`cmd_single`) it is 1. Otherwise it is min(remaining, block size).
- R4: `cmd_op`=2'b11 (set-multiple) loads the block size from `cmd_count[7:0]`. A value of 0 or a value above MAX_MULT loads MAX_MULT instead. The block size is MAX_MULT after reset. The command pulses `irq_set` once.
- R5: A read (`cmd_op`=2'b00) requests chunk after chunk from media. Each request carries `media_lba` equal to the start address plus all earlier chunks, and `media_wr`=0. After each chunk a buffer opens with `buf_bytes` equal to chunk × 512.
- R6: A verify (`cmd_op`=2'b10) opens no buffer. It issues the next media request directly after each completion.
- R7: Without DMA, `irq_set` pulses once per completed chunk. With DMA, a read pulses it once, when the final buffer is finished. A DMA write pulses it once, when the final media write completes.
- R8: A write (`cmd_op`=2'b01) opens a buffer of chunk × 512 bytes first. The media request (`media_wr`=1) follows the `buf_done` for that buffer. The command ends when the remaining count reaches 0.
- R9: If `prd_empty` accompanies a DMA read chunk completion, the remaining count is forced to 0. No buffer opens, the command ends and no interrupt is raised.
- R10: `media_done` with `media_err`=1 ends the command and drops any buffer. It sets `err_pending`, sets `err_code` to 2'b10 and pulses `irq_set`. The next accepted command clears `err_pending` and `err_code`.
- R11: `cmd_start` is ignored while `busy` is high, including in the cycle in which a command finishes.
- R12: After reset, `busy`, `buf_active`, `media_req`, `irq_set` and `err_pending` are 0, and `err_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 read, 01 write, 10 verify, 11 set-multiple |
| cmd_count | input | 16 | Raw sector count / block size |
| cmd_lba | input | LBA_W | Start sector address |
| cmd_cap | input | LBA_W | Capacity in sectors for the addressing mode |
| cmd_dma | input | 1 | DMA transfer |
| cmd_single | input | 1 | One sector per interrupt (PIO) |
| cmd_ext | input | 1 | 48-bit command |
| media_req | output | 1 | One-cycle media request |
| media_wr | output | 1 | Request is a write |
| media_lba | output | LBA_W | Request start sector |
| media_len | output | CH_W | Request length in sectors |
| media_done | input | 1 | Media request finished |
| media_err | input | 1 | Media request failed (with media_done) |
| prd_empty | input | 1 | DMA descriptors exhausted (with media_done) |
| buf_active | output | 1 | Data buffer window open |
| buf_bytes | output | CH_W+9 | Window size in bytes |
| buf_done | input | 1 | Window filled or drained |
| busy | output | 1 | Command in progress |
| irq_set | output | 1 | Interrupt set pulse |
| err_pending | output | 1 | Error flag |
| err_code | output | 2 | 01 bad range, 10 media fault |

## Verification
The case most likely to fail is a command finishing on the same clock edge that a new `cmd_start` arrives. This happens on the final `buf_done` of a read, where the state returns to idle on the very edge that samples the strobe. The bench sets up this collision by raising the strobe together with the last buffer handshake. A correct design shows no further media request, an unchanged interrupt count and no error. A second collision also matters: `prd_empty` or `media_err` arriving together with `media_done`. The bench judges it by checking that no buffer window follows the failed or truncated chunk.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_VERIFY  = 2'b10,
    OP_SETMULT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_RANGE = 2'b01,
    ERR_MEDIA = 2'b10
  } err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2,
    ST_BUF   = 2'd3
  } st_e;

  localparam int SECTOR_SHIFT = 9;
endpackage

// File: rtl/sxs_count_check.sv
module sxs_count_check #(
  parameter int LBA_W   = 48,
  parameter int RAW_W   = 16,
  parameter int SHORT_W = 8,
  localparam int CNT_W  = RAW_W + 1
) (
  input  logic [RAW_W-1:0] raw_count,
  input  logic             ext,
  input  logic [LBA_W-1:0] lba,
  input  logic [LBA_W-1:0] cap,
  output logic [CNT_W-1:0] cnt_eff,
  output logic             in_range
);
  localparam logic [CNT_W-1:0] LONG_MAX  = CNT_W'(1) << RAW_W;
  localparam logic [CNT_W-1:0] SHORT_MAX = CNT_W'(1) << SHORT_W;

  logic [SHORT_W-1:0] short_cnt;

  always_comb begin
    short_cnt = raw_count[SHORT_W-1:0];
    if (ext) begin
      cnt_eff = (raw_count == '0) ? LONG_MAX : CNT_W'(raw_count);
    end else begin
      cnt_eff = (short_cnt == '0) ? SHORT_MAX : CNT_W'(short_cnt);
    end
    in_range = (lba <= cap) && ((cap - lba) >= LBA_W'(cnt_eff));
  end
endmodule

// File: rtl/sxs_chunk_calc.sv
module sxs_chunk_calc #(
  parameter int CNT_W    = 17,
  parameter int MAX_MULT = 128,
  localparam int CH_W    = $clog2(MAX_MULT + 1)
) (
  input  logic [CNT_W-1:0] remaining,
  input  logic             dma,
  input  logic             single,
  input  logic [CH_W-1:0]  blk_size,
  output logic [CH_W-1:0]  chunk
);
  logic [CNT_W-1:0] limit;

  always_comb begin
    if (dma)         limit = CNT_W'(MAX_MULT);
    else if (single) limit = CNT_W'(1);
    else             limit = CNT_W'(blk_size);
    chunk = (remaining < limit) ? CH_W'(remaining) : CH_W'(limit);
  end
endmodule

// File: rtl/sxs_blk_reg.sv
module sxs_blk_reg #(
  parameter int MAX_MULT = 128,
  parameter int SHORT_W  = 8,
  localparam int CH_W    = $clog2(MAX_MULT + 1)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               load,
  input  logic [SHORT_W-1:0] req,
  output logic [CH_W-1:0]    blk_size
);
  logic [CH_W-1:0] blk_q, blk_d;

  always_comb begin
    blk_d = blk_q;
    if (load) begin
      if ((req == '0) || (32'(req) > MAX_MULT)) blk_d = CH_W'(MAX_MULT);
      else                                      blk_d = CH_W'(req);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) blk_q <= CH_W'(MAX_MULT);
    else if (load) blk_q <= blk_d;
  end

  assign blk_size = blk_q;

  // R4
  blk_zero_fallback_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (load && (req == '0)) |=> (32'(blk_q) == MAX_MULT));
endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq
  import sxs_pkg::*;
#(
  parameter int LBA_W    = 48,
  parameter int MAX_MULT = 128,
  localparam int CH_W    = $clog2(MAX_MULT + 1),
  localparam int BB_W    = CH_W + SECTOR_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_op,
  input  logic [15:0]      cmd_count,
  input  logic [LBA_W-1:0] cmd_lba,
  input  logic [LBA_W-1:0] cmd_cap,
  input  logic             cmd_dma,
  input  logic             cmd_single,
  input  logic             cmd_ext,
  output logic             media_req,
  output logic             media_wr,
  output logic [LBA_W-1:0] media_lba,
  output logic [CH_W-1:0]  media_len,
  input  logic             media_done,
  input  logic             media_err,
  input  logic             prd_empty,
  output logic             buf_active,
  output logic [BB_W-1:0]  buf_bytes,
  input  logic             buf_done,
  output logic             busy,
  output logic             irq_set,
  output logic             err_pending,
  output logic [1:0]       err_code
);
  localparam int RAW_W   = 16;
  localparam int SHORT_W = 8;
  localparam int CNT_W   = RAW_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  st_e              st_q, st_d;
  op_e              op_q, op_d;
  err_e             errc_q, errc_d;
  logic [CNT_W-1:0] rem_q, rem_d, rem_after;
  logic [LBA_W-1:0] lba_q, lba_d;
  logic [CH_W-1:0]  chunk_q, chunk_d, chunk_c, blk_size;
  logic             dma_q, dma_d, single_q, single_d;
  logic             irq_q, irq_d, errp_q, errp_d;
  logic             blk_load, exhausted;
  logic [CNT_W-1:0] cnt_eff;
  logic             in_range;

  sxs_count_check #(.LBA_W(LBA_W), .RAW_W(RAW_W), .SHORT_W(SHORT_W)) u_cnt (
    .raw_count (cmd_count),
    .ext       (cmd_ext),
    .lba       (cmd_lba),
    .cap       (cmd_cap),
    .cnt_eff   (cnt_eff),
    .in_range  (in_range)
  );

  sxs_blk_reg #(.MAX_MULT(MAX_MULT), .SHORT_W(SHORT_W)) u_blk (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (blk_load),
    .req      (cmd_count[SHORT_W-1:0]),
    .blk_size (blk_size)
  );

  sxs_chunk_calc #(.CNT_W(CNT_W), .MAX_MULT(MAX_MULT)) u_chunk (
    .remaining (rem_q),
    .dma       (dma_q),
    .single    (single_q),
    .blk_size  (blk_size),
    .chunk     (chunk_c)
  );

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    rem_d     = rem_q;
    lba_d     = lba_q;
    chunk_d   = chunk_q;
    dma_d     = dma_q;
    single_d  = single_q;
    errp_d    = errp_q;
    errc_d    = errc_q;
    irq_d     = 1'b0;
    blk_load  = 1'b0;
    exhausted = 1'b0;
    rem_after = rem_q - CNT_W'(chunk_q);
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_start) begin
          errp_d = 1'b0;
          errc_d = ERR_NONE;
          if (op_e'(cmd_op) == OP_SETMULT) begin
            blk_load = 1'b1;
            irq_d    = 1'b1;
          end else if (!in_range) begin
            errp_d = 1'b1;
            errc_d = ERR_RANGE;
            irq_d  = 1'b1;
          end else begin
            op_d     = op_e'(cmd_op);
            rem_d    = cnt_eff;
            lba_d    = cmd_lba;
            dma_d    = cmd_dma;
            single_d = cmd_single;
            st_d     = (op_e'(cmd_op) == OP_WRITE) ? ST_BUF : ST_MREQ;
          end
        end
      end
      ST_MREQ: begin
        chunk_d = chunk_c;
        st_d    = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (media_done) begin
          if (media_err) begin
            errp_d = 1'b1;
            errc_d = ERR_MEDIA;
            irq_d  = 1'b1;
            rem_d  = '0;
            st_d   = ST_IDLE;
          end else begin
            lba_d = lba_q + LBA_W'(chunk_q);
            if (op_q == OP_WRITE) begin
              rem_d = rem_after;
              if (rem_after == '0) begin
                st_d  = ST_IDLE;
                irq_d = 1'b1;
              end else begin
                st_d  = ST_BUF;
                irq_d = !dma_q;
              end
            end else begin
              exhausted = dma_q && prd_empty && (op_q == OP_READ);
              rem_d     = exhausted ? '0 : rem_after;
              irq_d     = !dma_q;
              if (op_q == OP_VERIFY) st_d = (rem_after == '0) ? ST_IDLE : ST_MREQ;
              else if (exhausted)    st_d = ST_IDLE;
              else                   st_d = ST_BUF;
            end
          end
        end
      end
      ST_BUF: begin
        if (buf_done) begin
          if (op_q == OP_WRITE) begin
            st_d = ST_MREQ;
          end else if (rem_q == '0) begin
            st_d  = ST_IDLE;
            irq_d = dma_q;
          end else begin
            st_d = ST_MREQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_READ;
      rem_q    <= '0;
      lba_q    <= '0;
      chunk_q  <= '0;
      dma_q    <= 1'b0;
      single_q <= 1'b0;
      irq_q    <= 1'b0;
      errp_q   <= 1'b0;
      errc_q   <= ERR_NONE;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      rem_q    <= rem_d;
      lba_q    <= lba_d;
      chunk_q  <= chunk_d;
      dma_q    <= dma_d;
      single_q <= single_d;
      irq_q    <= irq_d;
      errp_q   <= errp_d;
      errc_q   <= errc_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign media_req   = (st_q == ST_MREQ);
  assign media_wr    = (op_q == OP_WRITE);
  assign media_lba   = lba_q;
  assign media_len   = chunk_c;
  assign buf_active  = (st_q == ST_BUF);
  assign buf_bytes   = buf_active ? (BB_W'((op_q == OP_WRITE) ? chunk_c : chunk_q) << SECTOR_SHIFT)
                                  : '0;
  assign irq_set     = irq_q;
  assign err_pending = errp_q;
  assign err_code    = errc_q;

  // R3
  chunk_le_rem_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    media_req |-> ((media_len != '0) && (CNT_W'(media_len) <= rem_q)));

  // R8
  write_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (media_req && media_wr) |-> $past(buf_done));

  // R6
  verify_no_buf_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_MWAIT && media_done && !media_err && op_q == OP_VERIFY) |=> !buf_active);

  // R10
  media_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_MWAIT && media_done && media_err) |=> (!busy && err_pending && irq_set));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && cmd_start) |=> ($stable(op_q) && $stable(dma_q) && $stable(single_q)));
endmodule

// File: tb/sim_sector_xfer_seq.sv
module sim_sector_xfer_seq;
  localparam int LBA_W = 48;
  localparam int MM    = 128;
  localparam int CH_W  = 8;

  typedef struct { longint lba; int len; bit wr; } med_t;

  logic clk, rst_n;
  logic start_a, start_b, cmd_start;
  logic [1:0] cmd_op;
  logic [15:0] cmd_count;
  logic [LBA_W-1:0] cmd_lba, cmd_cap;
  logic cmd_dma, cmd_single, cmd_ext;
  logic media_req, media_wr;
  logic [LBA_W-1:0] media_lba;
  logic [CH_W-1:0] media_len;
  logic media_done, media_err, prd_empty;
  logic buf_active, buf_done, busy, irq_set, err_pending;
  logic [CH_W+8:0] buf_bytes;
  logic [1:0] err_code;

  assign cmd_start = start_a | start_b;

  sector_xfer_seq #(.LBA_W(LBA_W), .MAX_MULT(MM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_lba(cmd_lba), .cmd_cap(cmd_cap),
    .cmd_dma(cmd_dma), .cmd_single(cmd_single), .cmd_ext(cmd_ext),
    .media_req(media_req), .media_wr(media_wr), .media_lba(media_lba),
    .media_len(media_len), .media_done(media_done), .media_err(media_err),
    .prd_empty(prd_empty), .buf_active(buf_active), .buf_bytes(buf_bytes),
    .buf_done(buf_done), .busy(busy), .irq_set(irq_set),
    .err_pending(err_pending), .err_code(err_code));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // scoreboard state: driver pushes, monitor consumes by index
  med_t exp_med[$];
  int   exp_buf[$];
  int   rd_med, rd_buf, irq_cnt, mchecks, merrs;
  int   err_at, prd_at, cmd_seq, seen_seq, idx;
  bit   sod;
  int   med_wait, buf_wait;
  bit   buf_seen;
  int   checks, errs;
  int   exp_blk;

  // monitor and media/host responder
  always @(negedge clk) begin
    media_done = 1'b0; media_err = 1'b0; prd_empty = 1'b0;
    buf_done = 1'b0; start_b = 1'b0;
    if (!rst_n) begin
      rd_med = 0; rd_buf = 0; irq_cnt = 0; mchecks = 0; merrs = 0;
      seen_seq = 0; idx = 0; med_wait = 0; buf_wait = 0; buf_seen = 1'b0;
    end else begin
      if (cmd_seq != seen_seq) begin seen_seq = cmd_seq; idx = 0; end
      if (irq_set) irq_cnt++;
      if (media_req) begin
        mchecks++;
        if (rd_med >= exp_med.size()) begin
          merrs++;
          $display("FAIL R11 unexpected media request act lba=%0d exp=none", media_lba);
        end else begin
          if (longint'(media_lba) != exp_med[rd_med].lba || int'(media_len) != exp_med[rd_med].len
              || media_wr != exp_med[rd_med].wr) begin
            merrs++;
            $display("FAIL R5/R3/R8 media request act lba=%0d len=%0d wr=%0d exp lba=%0d len=%0d wr=%0d",
                     media_lba, media_len, media_wr, exp_med[rd_med].lba,
                     exp_med[rd_med].len, exp_med[rd_med].wr);
          end
          rd_med++;
        end
        med_wait = 2;
      end else if (med_wait > 0) begin
        med_wait--;
        if (med_wait == 0) begin
          media_done = 1'b1;
          media_err  = (idx == err_at);
          prd_empty  = (idx == prd_at);
          idx++;
        end
      end
      if (buf_wait > 0) begin
        buf_wait--;
        if (buf_wait == 0) begin
          buf_done = 1'b1;
          buf_seen = 1'b0;
          start_b  = sod && (rd_buf == exp_buf.size());
        end
      end else if (buf_active && !buf_seen) begin
        mchecks++;
        if (rd_buf >= exp_buf.size()) begin
          merrs++;
          $display("FAIL R6/R9 unexpected buffer act=%0d exp=none", buf_bytes);
        end else begin
          if (int'(buf_bytes) != exp_buf[rd_buf]) begin
            merrs++;
            $display("FAIL R5/R8 buffer size act=%0d exp=%0d", buf_bytes, exp_buf[rd_buf]);
          end
          rd_buf++;
        end
        buf_seen = 1'b1;
        buf_wait = 2;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks + mchecks, errs + merrs);
    $finish;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy) begin
      @(negedge clk);
      n++;
      if (n > 20000) begin
        chk(1'b0, "watchdog expired busy", 1, 0);
        finish_run();
      end
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic int xchunk(int rem, bit dma, bit single);
    int lim = dma ? MM : (single ? 1 : exp_blk);
    return (rem < lim) ? rem : lim;
  endfunction

  task automatic run(input string tag, input int op, input int cnt, input longint lba,
                     input longint cap, input bit dma, input bit single, input bit ext,
                     input int e_at, input int p_at, input bit mid, input bit on_done);
    int eff, rem, ch, k, irq_exp, irq0, code_exp;
    longint a;
    bit bad, ex;
    med_t m;
    irq_exp = 0; code_exp = 0;
    if (op == 3) begin
      exp_blk = ((cnt & 255) == 0 || (cnt & 255) > MM) ? MM : (cnt & 255);
      irq_exp = 1;
    end else begin
      if (ext) eff = (cnt == 0) ? 65536 : cnt;
      else     eff = ((cnt & 255) == 0) ? 256 : (cnt & 255);
      bad = (lba > cap) || ((cap - lba) < longint'(eff));
      if (bad) begin
        irq_exp = 1; code_exp = 1;
      end else begin
        rem = eff; a = lba; k = 0;
        while (rem > 0) begin
          ch = xchunk(rem, dma, single);
          m.lba = a; m.len = ch; m.wr = (op == 1);
          if (op == 1) begin
            exp_buf.push_back(ch * 512);
            exp_med.push_back(m);
            if (k == e_at) begin irq_exp++; code_exp = 2; break; end
            rem -= ch; a += ch;
            if (rem == 0) irq_exp++;
            else if (!dma) irq_exp++;
          end else begin
            exp_med.push_back(m);
            if (k == e_at) begin irq_exp++; code_exp = 2; break; end
            ex = dma && (k == p_at) && (op == 0);
            rem = ex ? 0 : rem - ch; a += ch;
            if (op == 0 && !ex) exp_buf.push_back(ch * 512);
            if (!dma) irq_exp++;
            else if (rem == 0 && !ex) irq_exp++;
          end
          k++;
        end
      end
    end
    irq0 = irq_cnt;
    err_at = e_at; prd_at = p_at; sod = on_done;
    @(negedge clk);
    cmd_seq++;
    cmd_op = 2'(op); cmd_count = 16'(cnt); cmd_lba = LBA_W'(lba); cmd_cap = LBA_W'(cap);
    cmd_dma = dma; cmd_single = single; cmd_ext = ext; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    if (mid) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, {tag, " busy before stray start"}, busy, 1);
      cmd_op = 2'b01; cmd_lba = '0; cmd_count = 16'd1; start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
    end
    wait_idle();
    sod = 1'b0;
    chk(rd_med == exp_med.size(), {tag, " media requests consumed"}, rd_med, exp_med.size());
    chk(rd_buf == exp_buf.size(), {tag, " buffers consumed"}, rd_buf, exp_buf.size());
    chk(irq_cnt - irq0 == irq_exp, {tag, " interrupt count"}, irq_cnt - irq0, irq_exp);
    chk(int'(err_code) == code_exp, {tag, " error code"}, err_code, code_exp);
    chk(err_pending == (code_exp != 0), {tag, " error pending"}, err_pending, code_exp != 0);
    chk(!busy && !buf_active, {tag, " idle at end"}, busy, 0);
  endtask

  initial begin
    checks = 0; errs = 0; cmd_seq = 0; exp_blk = MM; err_at = -1; prd_at = -1; sod = 1'b0;
    rst_n = 1'b0; start_a = 1'b0; cmd_op = 2'b00; cmd_count = '0; cmd_lba = '0; cmd_cap = '0;
    cmd_dma = 1'b0; cmd_single = 1'b0; cmd_ext = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(!busy, "R12 busy after reset", busy, 0);
    chk(!buf_active, "R12 buf_active after reset", buf_active, 0);
    chk(!media_req, "R12 media_req after reset", media_req, 0);
    chk(!irq_set, "R12 irq_set after reset", irq_set, 0);
    chk(!err_pending && err_code == 2'b00, "R12 error state after reset", err_code, 0);

    // R3 R5 R7: block chunks after set-multiple
    run("R4 setmult 4", 3, 4, 0, 0, 0, 0, 0, -1, -1, 0, 0);
    run("R3 R5 R7 pio block read", 0, 10, 50, 1000, 0, 0, 0, -1, -1, 0, 0);
    run("R4 setmult above max", 3, 200, 0, 0, 0, 0, 0, -1, -1, 0, 0);
    run("R4 fallback read ext", 0, 300, 7, 100000, 0, 0, 1, -1, -1, 0, 0);
    run("R4 setmult zero", 3, 0, 0, 0, 0, 0, 0, -1, -1, 0, 0);
    run("R3 blk read 130", 0, 130, 0, 1000, 0, 0, 0, -1, -1, 0, 0);
    run("R3 single read", 0, 3, 20, 1000, 0, 1, 0, -1, -1, 0, 0);
    // R1 zero counts and masking
    run("R1 R7 dma read zero 28", 0, 0, 100, 5000, 1, 0, 0, -1, -1, 0, 0);
    run("R1 28-bit high byte ignored", 0, 16'h0102, 3, 1000, 0, 0, 0, -1, -1, 0, 0);
    run("R1 dma read zero 48", 0, 0, 1, 1 << 20, 1, 0, 1, -1, -1, 0, 0);
    // R6 verify
    run("R6 verify single", 2, 3, 40, 1000, 0, 1, 0, -1, -1, 0, 0);
    run("R6 verify block", 2, 5, 40, 1000, 0, 0, 0, -1, -1, 0, 0);
    // R8 writes
    run("R8 pio write single", 1, 2, 60, 1000, 0, 1, 0, -1, -1, 0, 0);
    run("R8 pio write block", 1, 5, 61, 1000, 0, 0, 0, -1, -1, 0, 0);
    run("R7 R8 dma write ext", 1, 200, 9, 100000, 1, 0, 1, -1, -1, 0, 0);
    // R2 range
    run("R2 lba at capacity", 0, 1, 100, 100, 0, 0, 0, -1, -1, 0, 0);
    run("R2 lba past capacity", 0, 1, 101, 100, 0, 0, 0, -1, -1, 0, 0);
    run("R2 exact fit", 0, 10, 90, 100, 1, 0, 0, -1, -1, 0, 0);
    // R9 descriptor exhaustion
    run("R9 prd empty", 0, 300, 0, 100000, 1, 0, 1, -1, 1, 0, 0);
    // R10 media errors
    run("R10 read media error", 0, 3, 5, 1000, 0, 1, 0, 1, -1, 0, 0);
    run("R10 error cleared by next", 0, 1, 5, 1000, 0, 1, 0, -1, -1, 0, 0);
    run("R10 write media error", 1, 1, 5, 1000, 0, 1, 0, 0, -1, 0, 0);
    // R11 ignored starts
    run("R11 start while busy", 0, 4, 1000, 5000, 0, 1, 0, -1, -1, 1, 0);
    run("R11 start on final edge", 0, 2, 300, 5000, 0, 1, 0, -1, -1, 0, 1);
    repeat (10) @(negedge clk);
    chk(rd_med == exp_med.size() && !busy, "R11 no late command", rd_med, exp_med.size());
    finish_run();
  end
endmodule